// File: doc/BRIEF.md
# Serial Port Peripheral with Masked Interrupts

This block is an asynchronous serial port that sits on a framed slave bus. Each bus transfer carries a 2-bit frame kind and a byte. A control frame latches a selector byte whose low nibble picks one of sixteen register slots. Later write frames store their byte into that slot, and read frames return the slot's contents one cycle later. A reset frame returns the whole block to its power-on state.

The port holds a transmitter and a receiver. Both run on a 16x oversampling tick taken from a 16-bit divisor. The divisor is stored as a negated count, so one bit lasts 16 × (1 − divisor) clock cycles in signed 16-bit arithmetic. Character length, parity, stop bits and break are programmable. There are three modem inputs and two modem outputs. A 3-bit sticky interrupt status is gated by a mask to drive one interrupt line, and its bits are cleared as side effects of specific accesses. When the port is disabled, the register that drives the modem outputs instead feeds two plain output ports, first D and then C.

Register slots (selector low nibble): 2 mode (bit 0 enables the port), 3 modem/port write, 6 interrupt mask (read/write), 7 masked interrupt status (read), 8 line format (write) / line status (read), 9 transmit holding (write) / receive data (read), 10 divisor low byte, 11 divisor high byte.

Top module: `uartp_top`

## Requirements
- R1: On reset, and on any reset frame (kind 0), the interrupt status becomes 3'b010, the mask, mode and format registers clear, the divisor becomes 0xFFFF (a bit lasts 32 clocks) and the port D/C select points to port D.
- R2: The interrupt output is high exactly when status AND mask is non-zero. A read of slot 7 returns status AND mask in bits 2:0, with zeros above.
- R3: A write to slot 9 starts sending the byte and clears status bit 1. Bit 1 is set again in the cycle the last stop bit ends.
- R4: A read of slot 9 returns the received character and clears status bit 0. A read of slot 8 clears status bit 2.
- R5: A received character sets status bit 0. A framing or parity error on it also sets bit 2. Any change on the synchronised CTS, DSR or DCD inputs sets bit 2, and all three are taken as low just after reset.
- R6: Format byte: bits 2:1 give a length of 5 + value, bit 3 enables parity, bit 4 selects odd parity (even when clear) and bit 5 selects two stop bits. Frames are sent as a low start bit, then the data LSB first, then parity, then high stop bits. A format write aborts both shifters and clears the receive flags.
- R7: Format bit 0 forces the serial output low (break).
- R8: Writes to slots 10 and 11 set the low and high divisor bytes. A bit then lasts 16 × (1 − divisor) clocks, where the divisor is read as a signed value.
- R9: Line status byte: bit 0 CTS, bit 1 DSR, bit 2 DCD, bit 3 transmitter idle, bit 4 transmitter busy, bit 5 received byte waiting, bit 6 framing error or overrun, bit 7 parity error.
- R10: With mode bit 0 set, a slot 3 write drives RTS from data bit 1 and DTR from data bit 2. With it clear, the first slot 3 write after selector 0x93 goes to port D and later ones go to port C.
- R11: While mode bit 0 is clear, both shifters hold their state and the serial output stays high.
- R12: The receiver confirms a start bit at its middle (8 ticks after the falling edge). If the line is high by then, no character results.
- R13: If a character completes while the previous one is still unread, status bit 6 is set and the newer character replaces the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frmValid | input | 1 | Bus frame present this cycle |
| frmKind | input | 2 | 0 reset, 1 control, 2 data write, 3 data read |
| frmData | input | 8 | Selector or write byte |
| rdData | output | 8 | Read result, valid the cycle after a read frame |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| ctsIn | input | 1 | Clear-to-send input |
| dsrIn | input | 1 | Data-set-ready input |
| dcdIn | input | 1 | Carrier-detect input |
| rtsOut | output | 1 | Request-to-send output |
| dtrOut | output | 1 | Data-terminal-ready output |
| portD | output | 8 | Port D write register |
| portC | output | 8 | Port C write register |
| irq | output | 1 | Masked interrupt request |

## Verification
A wrong bit count or format decode shows up on txd within one character time. The bench samples txd at each bit centre and loops it back to rxd, so the same fault also shows in the received byte a few cycles after the stop bit. A sticky status bit that fails to set or clear is seen on the very next slot 7 read and on irq in the same cycle. A stuck D/C select or modem output is visible on the ports one cycle after the write frame.

// File: rtl/uartp_pkg.sv
package uartp_pkg;
  localparam int DIV_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {FRM_RST = 2'd0, FRM_CTL = 2'd1, FRM_WR = 2'd2, FRM_RD = 2'd3} frm_kind_t;

  localparam logic [3:0] REG_MODE = 4'h2;
  localparam logic [3:0] REG_DC   = 4'h3;
  localparam logic [3:0] REG_MASK = 4'h6;
  localparam logic [3:0] REG_IST  = 4'h7;
  localparam logic [3:0] REG_LINE = 4'h8;
  localparam logic [3:0] REG_DATA = 4'h9;
  localparam logic [3:0] REG_DLO  = 4'hA;
  localparam logic [3:0] REG_DHI  = 4'hB;
  localparam logic [7:0] SEL_DC_RESTART = 8'h93;

  // strobes and settings from control to datapath
  typedef struct packed {
    logic              clr;
    logic              txLoad;
    logic              shReset;
    logic              rxTake;
    logic              en;
    logic              brk;
    logic [1:0]        lenSel;
    logic              parEn;
    logic              parOdd;
    logic              twoStop;
    logic [BYTE_W-1:0] txByte;
    logic [DIV_W-1:0]  limit;
  } dp_cmd_t;

  // events and state from datapath to control
  typedef struct packed {
    logic              txDone;
    logic              rxDone;
    logic              rxErr;
    logic              txBusy;
    logic              rxFull;
    logic              rxFerrOvr;
    logic              rxPerr;
    logic [BYTE_W-1:0] rxByte;
  } dp_stat_t;
endpackage

// File: rtl/uartp_baud.sv
module uartp_baud
  import uartp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uartp_dp.sv
module uartp_dp
  import uartp_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  dp_cmd_t cmd,
  input  logic    rxd,
  output logic    txd,
  output dp_stat_t st
);
  localparam int PH_W = $clog2(OVS);
  localparam int FR_W = BYTE_W + 4;
  localparam logic [PH_W-1:0] PH_END = PH_W'(OVS - 1);
  localparam logic [PH_W-1:0] PH_MID = PH_W'(OVS / 2 - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;

  logic [3:0] len;
  logic [BYTE_W-1:0] lenMask, txData;
  logic [FR_W-1:0] txFrame, txSh;
  logic [3:0] txN, txLeft;
  logic [PH_W-1:0] txPh, rxPh;
  logic txBusy, txTick, rxTick, abort;
  rx_state_t rxSt;
  logic rxS1, rxS, rxParBit, rxFull, rxFerrOvr, rxPerr, perrNow, rxLast;
  logic [3:0] rxIdx;
  logic [BYTE_W-1:0] rxSh, rxByte;

  assign len     = 4'd5 + {2'b00, cmd.lenSel};
  assign lenMask = 8'hFF >> (4'd8 - len);
  assign txData  = cmd.txByte & lenMask;
  assign txN     = 4'd1 + len + {3'b000, cmd.parEn} + (cmd.twoStop ? 4'd2 : 4'd1);
  assign abort   = cmd.clr || cmd.shReset;

  always_comb begin
    txFrame = '1;
    txFrame[0] = 1'b0;
    for (int i = 0; i < BYTE_W; i++)
      if (i < int'(len)) txFrame[i+1] = txData[i];
    if (cmd.parEn) txFrame[len+4'd1] = (^txData) ^ cmd.parOdd;
  end

  uartp_baud uTxBaud (.clk(clk), .rstN(rstN), .run(cmd.en && txBusy), .limit(cmd.limit), .tick(txTick));
  uartp_baud uRxBaud (.clk(clk), .rstN(rstN), .run(cmd.en && rxSt != RX_IDLE), .limit(cmd.limit), .tick(rxTick));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy <= 1'b0; txSh <= '1; txLeft <= '0; txPh <= '0;
    end else if (abort) begin
      txBusy <= 1'b0; txSh <= '1; txLeft <= '0; txPh <= '0;
    end else if (cmd.txLoad) begin
      txBusy <= 1'b1; txSh <= txFrame; txLeft <= txN; txPh <= '0;
    end else if (txTick) begin
      if (txPh == PH_END) begin
        txPh   <= '0;
        txSh   <= {1'b1, txSh[FR_W-1:1]};
        txLeft <= txLeft - 1'b1;
        if (txLeft == 4'd1) txBusy <= 1'b0;
      end else txPh <= txPh + 1'b1;
    end
  end

  assign txd = cmd.brk ? 1'b0 : ((cmd.en && txBusy) ? txSh[0] : 1'b1);

  // receiver
  assign perrNow = cmd.parEn && (((^rxSh) ^ rxParBit) != cmd.parOdd);
  assign rxLast  = (rxIdx == len + {3'b000, cmd.parEn});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxS1 <= 1'b1; rxS <= 1'b1;
    end else begin
      rxS1 <= rxd; rxS <= rxS1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSt <= RX_IDLE; rxPh <= '0; rxIdx <= '0; rxSh <= '0; rxParBit <= 1'b0;
      rxByte <= '0; rxFull <= 1'b0; rxFerrOvr <= 1'b0; rxPerr <= 1'b0;
    end else if (abort) begin
      rxSt <= RX_IDLE; rxPh <= '0; rxIdx <= '0;
      rxFull <= 1'b0; rxFerrOvr <= 1'b0; rxPerr <= 1'b0;
    end else begin
      if (cmd.rxTake) rxFull <= 1'b0;
      unique case (rxSt)
        RX_IDLE: if (cmd.en && !rxS) begin rxSt <= RX_START; rxPh <= '0; end
        RX_START: if (rxTick) begin
          if (rxPh == PH_MID) begin
            if (!rxS) begin rxSt <= RX_BITS; rxPh <= '0; rxIdx <= '0; rxSh <= '0; end
            else rxSt <= RX_IDLE;
          end else rxPh <= rxPh + 1'b1;
        end
        RX_BITS: if (rxTick) begin
          if (rxPh == PH_END) begin
            rxPh  <= '0;
            rxIdx <= rxIdx + 1'b1;
            if (rxIdx < len) rxSh[rxIdx[2:0]] <= rxS;
            else if (!rxLast) rxParBit <= rxS;
            else begin
              rxSt      <= RX_IDLE;
              rxByte    <= rxSh;
              rxFull    <= 1'b1;
              rxFerrOvr <= !rxS || (rxFull && !cmd.rxTake);
              rxPerr    <= perrNow;
            end
          end else rxPh <= rxPh + 1'b1;
        end
        default: rxSt <= RX_IDLE;
      endcase
    end
  end

  assign st.txDone    = txTick && txPh == PH_END && txLeft == 4'd1 && !abort && !cmd.txLoad;
  assign st.rxDone    = rxSt == RX_BITS && rxTick && rxPh == PH_END && rxLast && !abort;
  assign st.rxErr     = !rxS || perrNow;
  assign st.txBusy    = txBusy;
  assign st.rxFull    = rxFull;
  assign st.rxFerrOvr = rxFerrOvr;
  assign st.rxPerr    = rxPerr;
  assign st.rxByte    = rxByte;
endmodule

// File: rtl/uartp_ctl.sv
module uartp_ctl
  import uartp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frmValid,
  input  logic [1:0]        frmKind,
  input  logic [BYTE_W-1:0] frmData,
  input  logic              ctsIn,
  input  logic              dsrIn,
  input  logic              dcdIn,
  input  dp_stat_t          st,
  output dp_cmd_t           cmd,
  output logic [BYTE_W-1:0] rdData,
  output logic              rtsOut,
  output logic              dtrOut,
  output logic [BYTE_W-1:0] portD,
  output logic [BYTE_W-1:0] portC,
  output logic              irq,
  output logic [2:0]        istat,
  output logic [BYTE_W-1:0] mask
);
  logic [BYTE_W-1:0] selByte, modeReg, fmtReg, lineSt;
  logic [DIV_W-1:0] divisor;
  logic [2:0] ist, istNext, mSync1, mSync2, mPrev;
  logic dcSel, clr, wr, rd;
  logic [3:0] addr;

  assign clr  = frmValid && frmKind == FRM_RST;
  assign wr   = frmValid && frmKind == FRM_WR;
  assign rd   = frmValid && frmKind == FRM_RD;
  assign addr = selByte[3:0];

  assign lineSt = {st.rxPerr, st.rxFerrOvr, st.rxFull, st.txBusy, !st.txBusy, mSync2};

  always_comb begin
    istNext = ist;
    if (st.txDone) istNext[1] = 1'b1;
    if (cmd.txLoad) istNext[1] = 1'b0;
    if (rd && addr == REG_LINE) istNext[2] = 1'b0;
    if (cmd.rxTake) istNext[0] = 1'b0;
    if (st.rxDone) begin
      istNext[0] = 1'b1;
      if (st.rxErr) istNext[2] = 1'b1;
    end
    if (mSync2 != mPrev) istNext[2] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selByte <= '0; modeReg <= '0; fmtReg <= '0; mask <= '0; divisor <= '1;
      ist <= 3'b010; dcSel <= 1'b0; rtsOut <= 1'b0; dtrOut <= 1'b0;
      portD <= '0; portC <= '0; rdData <= '0;
      mSync1 <= '0; mSync2 <= '0; mPrev <= '0;
    end else if (clr) begin
      selByte <= '0; modeReg <= '0; fmtReg <= '0; mask <= '0; divisor <= '1;
      ist <= 3'b010; dcSel <= 1'b0; rtsOut <= 1'b0; dtrOut <= 1'b0;
      mSync1 <= {dcdIn, dsrIn, ctsIn}; mSync2 <= mSync1; mPrev <= mSync2;
    end else begin
      mSync1 <= {dcdIn, dsrIn, ctsIn};
      mSync2 <= mSync1;
      mPrev  <= mSync2;
      ist    <= istNext;
      if (frmValid && frmKind == FRM_CTL) begin
        selByte <= frmData;
        if (frmData == SEL_DC_RESTART) dcSel <= 1'b0;
      end
      if (wr) begin
        unique case (addr)
          REG_MODE: modeReg <= frmData;
          REG_MASK: mask <= frmData;
          REG_LINE: fmtReg <= frmData;
          REG_DLO:  divisor[7:0] <= frmData;
          REG_DHI:  divisor[15:8] <= frmData;
          REG_DC: if (modeReg[0]) begin
            rtsOut <= frmData[1];
            dtrOut <= frmData[2];
          end else begin
            if (dcSel) portC <= frmData;
            else portD <= frmData;
            dcSel <= 1'b1;
          end
          default: ;
        endcase
      end
      if (rd) begin
        unique case (addr)
          REG_MASK: rdData <= mask;
          REG_IST:  rdData <= {5'b0, ist & mask[2:0]};
          REG_LINE: rdData <= lineSt;
          REG_DATA: rdData <= st.rxByte;
          default:  rdData <= '0;
        endcase
      end
    end
  end

  assign istat = ist;
  assign irq   = |(ist & mask[2:0]);

  assign cmd.clr     = clr;
  assign cmd.txLoad  = wr && addr == REG_DATA;
  assign cmd.shReset = wr && addr == REG_LINE;
  assign cmd.rxTake  = rd && addr == REG_DATA;
  assign cmd.en      = modeReg[0];
  assign cmd.brk     = fmtReg[0];
  assign cmd.lenSel  = fmtReg[2:1];
  assign cmd.parEn   = fmtReg[3];
  assign cmd.parOdd  = fmtReg[4];
  assign cmd.twoStop = fmtReg[5];
  assign cmd.txByte  = frmData;
  assign cmd.limit   = ~divisor + 16'd1;
endmodule

// File: rtl/uartp_top.sv
module uartp_top
  import uartp_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frmValid,
  input  logic [1:0]  frmKind,
  input  logic [7:0]  frmData,
  output logic [7:0]  rdData,
  input  logic        rxd,
  output logic        txd,
  input  logic        ctsIn,
  input  logic        dsrIn,
  input  logic        dcdIn,
  output logic        rtsOut,
  output logic        dtrOut,
  output logic [7:0]  portD,
  output logic [7:0]  portC,
  output logic        irq
);
  dp_cmd_t cmd;
  dp_stat_t st;
  logic [2:0] istat;
  logic [7:0] mask;

  uartp_ctl uCtl (
    .clk(clk), .rstN(rstN), .frmValid(frmValid), .frmKind(frmKind), .frmData(frmData),
    .ctsIn(ctsIn), .dsrIn(dsrIn), .dcdIn(dcdIn), .st(st), .cmd(cmd), .rdData(rdData),
    .rtsOut(rtsOut), .dtrOut(dtrOut), .portD(portD), .portC(portC), .irq(irq),
    .istat(istat), .mask(mask)
  );

  uartp_dp #(.OVS(OVS)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rxd(rxd), .txd(txd), .st(st)
  );
endmodule

// File: rtl/uartp_chk.sv
module uartp_chk
  import uartp_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input dp_cmd_t  cmd,
  input dp_stat_t st,
  input logic [2:0] istat,
  input logic [7:0] mask,
  input logic     irq
);
  AST_CLR_DEFAULTS: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clr |=> (istat == 3'b010 && mask == 8'h00)); // R1
  AST_NO_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    (mask[2:0] == 3'b000) |-> !irq); // R2
  AST_LOAD_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    cmd.txLoad |=> !istat[1]); // R3
  AST_DONE_SETS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    st.txDone |=> istat[1]); // R3
  AST_TAKE_CLEARS_RX: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.rxTake && !st.rxDone) |=> !istat[0]); // R4
  AST_RX_ERR_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (st.rxDone && st.rxErr) |=> (istat[2] && istat[0])); // R5
  AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.en && !cmd.clr && !cmd.shReset && !cmd.txLoad) |=> $stable(st.txBusy)); // R11
endmodule

bind uartp_top uartp_chk uChk (
  .clk(clk), .rstN(rstN), .cmd(cmd), .st(st), .istat(istat), .mask(mask), .irq(irq)
);

// File: tb/sim_uartp_top.sv
module sim_uartp_top;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frmValid = 1'b0;
  logic [1:0] frmKind = 2'd0;
  logic [7:0] frmData = 8'h00;
  logic rxDrv = 1'b1, loopOn = 1'b0;
  logic ctsIn = 1'b0, dsrIn = 1'b0, dcdIn = 1'b0;
  logic [7:0] rdData, portD, portC;
  logic txd, rtsOut, dtrOut, irq, rxd;
  int nChk = 0, nErr = 0;
  bit done = 1'b0;

  assign rxd = loopOn ? txd : rxDrv;
  always #(CLK_NS/2) clk = ~clk;

  uartp_top u0 (
    .clk(clk), .rstN(rstN), .frmValid(frmValid), .frmKind(frmKind), .frmData(frmData),
    .rdData(rdData), .rxd(rxd), .txd(txd), .ctsIn(ctsIn), .dsrIn(dsrIn), .dcdIn(dcdIn),
    .rtsOut(rtsOut), .dtrOut(dtrOut), .portD(portD), .portC(portC), .irq(irq)
  );

  task automatic ck(input string tag, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busOp(input logic [1:0] k, input logic [7:0] d);
    @(negedge clk);
    frmValid = 1'b1; frmKind = k; frmData = d;
    @(negedge clk);
    frmValid = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    busOp(2'd1, {4'h0, a});
    busOp(2'd2, d);
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    busOp(2'd1, {4'h0, a});
    busOp(2'd3, 8'h00);
    v = int'(rdData);
  endtask

  task automatic lowLen(output int c);
    c = 0;
    while (txd == 1'b0 && c < 5000) begin c++; @(negedge clk); end
  endtask

  task automatic drvBits(input logic [11:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rxDrv = v[i];
      repeat (15) @(negedge clk);
    end
    @(negedge clk); rxDrv = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  // transmit one character in loopback, check line bits and receive side
  task automatic sweepOne(input int len, input int par, input int odd, input int two, input int data);
    int n, dm, got, expF, v;
    dm = data % (1 << len);
    n = 1 + len + par + (two ? 2 : 1);
    expF = dm << 1;
    if (par) expF |= ((($countones(dm) + odd) % 2) << (len + 1));
    for (int k = 1 + len + par; k < n; k++) expF |= (1 << k);
    wr(4'h8, 8'(((two << 5) | (odd << 4) | (par << 3) | ((len - 5) << 1))));
    wr(4'h9, 8'(data));
    got = 0;
    repeat (8) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (k > 0) repeat (16) @(negedge clk);
      got |= (int'(txd) << k);
    end
    repeat (8) @(negedge clk);
    ck("R6 frame bits", got, expF);
    rd(4'h7, v); ck("R3 tx empty and R5 rx flag", v, 3);
    rd(4'h8, v); ck("R9 line status after rx", v, 8'h28);
    rd(4'h9, v); ck("R4 rx data", v, dm);
    rd(4'h7, v); ck("R4 rx flag cleared", v, 2);
  endtask

  initial begin
    int v, c;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 / R2 reset state
    ck("R2 irq at reset", int'(irq), 0);
    rd(4'h7, v); ck("R2 masked status at reset", v, 0);
    rd(4'h6, v); ck("R1 mask at reset", v, 0);
    wr(4'h6, 8'hFF);
    ck("R2 irq with tx empty unmasked", int'(irq), 1);
    rd(4'h7, v); ck("R1 status reset value", v, 2);
    // R1 / R8 default divisor: 32 clocks per bit
    wr(4'h2, 8'h01);
    wr(4'h9, 8'h1F);
    lowLen(c); ck("R1 default bit time", c, 32);
    repeat (300) @(negedge clk);
    wr(4'hA, 8'hFD); wr(4'hB, 8'hFF);
    wr(4'h9, 8'h1F);
    lowLen(c); ck("R8 divisor -3 bit time", c, 64);
    repeat (7 * 64 + 20) @(negedge clk);
    wr(4'hA, 8'h00); wr(4'hB, 8'h00);
    wr(4'h9, 8'h1F);
    lowLen(c); ck("R8 divisor 0 bit time", c, 16);
    repeat (150) @(negedge clk);
    // R6 sweep of formats in loopback
    loopOn = 1'b1;
    for (int len = 5; len <= 8; len++)
      for (int pm = 0; pm < 3; pm++)
        for (int two = 0; two < 2; two++)
          for (int di = 0; di < 3; di++)
            sweepOne(len, pm != 0, pm == 2, two, (di == 0) ? 8'hA5 : (di == 1) ? 8'h3C : 8'hFE);
    loopOn = 1'b0;
    // R7 break
    wr(4'h8, 8'h01); ck("R7 break low", int'(txd), 0);
    wr(4'h8, 8'h06); ck("R7 break released", int'(txd), 1);
    // R6 format write aborts transmitter
    wr(4'h9, 8'h00);
    repeat (40) @(negedge clk);
    wr(4'h8, 8'h06);
    ck("R6 abort line idle", int'(txd), 1);
    rd(4'h8, v); ck("R6 abort status", v, 8'h08);
    rd(4'h7, v); ck("R3 no completion after abort", v, 0);
    wr(4'h9, 8'hFF);
    repeat (10 * 16 + 10) @(negedge clk);
    rd(4'h7, v); ck("R3 empty after full char", v, 2);
    // R5 / R9 framing error
    drvBits({2'b00, 1'b0, 8'h5A, 1'b0}, 10);
    rd(4'h7, v); ck("R5 framing error flags", v, 7);
    rd(4'h8, v); ck("R9 framing error status", v, 8'h68);
    rd(4'h7, v); ck("R4 status read clears bit 2", v, 3);
    rd(4'h9, v); ck("R4 rx data after ferr", v, 8'h5A);
    // R5 parity error: even parity, data 0x01, parity sent as 0
    wr(4'h8, 8'h0E);
    drvBits({1'b0, 1'b1, 1'b0, 8'h01, 1'b0}, 11);
    rd(4'h7, v); ck("R5 parity error flags", v, 7);
    rd(4'h8, v); ck("R9 parity error status", v, 8'hA8);
    rd(4'h9, v); ck("R4 rx data after perr", v, 8'h01);
    // R13 overrun
    wr(4'h8, 8'h06);
    drvBits({2'b00, 1'b1, 8'h11, 1'b0}, 10);
    drvBits({2'b00, 1'b1, 8'h22, 1'b0}, 10);
    rd(4'h7, v); ck("R13 overrun no error interrupt", v, 3);
    rd(4'h8, v); ck("R13 overrun status", v, 8'h68);
    rd(4'h9, v); ck("R13 newer byte kept", v, 8'h22);
    // R12 false start
    wr(4'h8, 8'h06);
    @(negedge clk); rxDrv = 1'b0;
    repeat (4) @(negedge clk); rxDrv = 1'b1;
    repeat (200) @(negedge clk);
    rd(4'h7, v); ck("R12 false start no char", v, 2);
    rd(4'h8, v); ck("R12 false start status", v, 8'h08);
    // R5 / R9 modem lines
    ctsIn = 1'b1; repeat (4) @(negedge clk);
    rd(4'h7, v); ck("R5 cts change", v, 6);
    rd(4'h8, v); ck("R9 cts bit", v, 8'h09);
    rd(4'h7, v); ck("R4 modem flag cleared", v, 2);
    dsrIn = 1'b1; dcdIn = 1'b1; repeat (4) @(negedge clk);
    rd(4'h8, v); ck("R9 dsr and dcd bits", v, 8'h0F);
    ctsIn = 1'b0; dsrIn = 1'b0; dcdIn = 1'b0; repeat (4) @(negedge clk);
    rd(4'h7, v); ck("R5 modem drop", v, 6);
    rd(4'h8, v);
    // R2 masking
    wr(4'h6, 8'h01);
    ck("R2 irq masked off", int'(irq), 0);
    rd(4'h7, v); ck("R2 masked read", v, 0);
    wr(4'h6, 8'hFF);
    // R11 disabled shifters
    wr(4'h8, 8'h00);
    wr(4'h2, 8'h00);
    wr(4'h9, 8'h00);
    c = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (txd !== 1'b1) c++; end
    ck("R11 line held idle", c, 0);
    rd(4'h7, v); ck("R11 no progress while off", v, 0);
    wr(4'h2, 8'h01);
    repeat (7 * 16 + 20) @(negedge clk);
    rd(4'h7, v); ck("R11 resumes when enabled", v, 2);
    // R10 modem outputs and port D/C
    wr(4'h3, 8'h06);
    ck("R10 rts set", int'(rtsOut), 1); ck("R10 dtr set", int'(dtrOut), 1);
    wr(4'h3, 8'h02);
    ck("R10 dtr clear", int'(dtrOut), 0); ck("R10 port D untouched", int'(portD), 0);
    wr(4'h2, 8'h00);
    busOp(2'd1, 8'h93); busOp(2'd2, 8'h11);
    ck("R10 first write to D", int'(portD), 8'h11);
    busOp(2'd1, 8'h03); busOp(2'd2, 8'h22);
    ck("R10 second write to C", int'(portC), 8'h22);
    busOp(2'd2, 8'h33);
    ck("R10 third write to C", int'(portC), 8'h33); ck("R10 D kept", int'(portD), 8'h11);
    busOp(2'd1, 8'h93); busOp(2'd2, 8'h44);
    ck("R10 restart to D", int'(portD), 8'h44); ck("R10 rts kept", int'(rtsOut), 1);
    // R1 reset frame
    busOp(2'd0, 8'h00);
    ck("R1 rts after reset frame", int'(rtsOut), 0);
    rd(4'h6, v); ck("R1 mask after reset frame", v, 0);
    wr(4'h6, 8'hFF);
    rd(4'h7, v); ck("R1 status after reset frame", v, 2);
    busOp(2'd1, 8'h03); busOp(2'd2, 8'h55);
    ck("R1 D/C select after reset frame", int'(portD), 8'h55);
    wr(4'h2, 8'h01);
    wr(4'h9, 8'h1F);
    lowLen(c); ck("R1 divisor after reset frame", c, 32);
    repeat (250) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nErr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
      $finish;
    end
  end
endmodule